// File: doc/BRIEF.md
# Masked PID Filter with Key Selection

This block decides, once per transport packet, which descrambling key pair applies to the packet's 13-bit PID. It holds six programmable filter slots. Each slot has a PID value, a 3-bit key pair index and a flag that marks the stream as carrying PES-level scrambling. The last slot also has a per-bit compare mask, so it can act as a wildcard that covers a family of PIDs. A global default-key enable overrides every slot. For each lookup the block reports whether anything matched, whether the default key won, which slot won, and that slot's key pair index and PES flag. It does not store key material and does not run any cipher.

Lookups arrive on a valid/ready input that carries the PID once the packet header has delivered it. Results leave on a valid/ready output through a single register stage. The input is ready whenever the output register is empty or is being drained in the same cycle. While `res_valid` is high and `res_ready` is low, the result and all of its fields are held unchanged and no new lookup is accepted. A plain write port programs the slots. A write changes only lookups accepted after it, so a result already produced for a packet is never disturbed.

Top module: `pidf_key_select`

## Requirements
- R1: After reset every slot index is 3'b111, every PID is 0, every mask bit is 1 and the default key is off, so every lookup misses. Also after reset, `in_ready` is 1 and `res_valid` is 0.
- R2: A lookup whose PID equals an active slot's PID reports `res_hit`=1, `res_dcw`=0, and that slot's number, index and PES flag.
- R3: A slot whose index is 3'b110 or 3'b111 never matches. Index codes 3'b000 to 3'b101 are active.
- R4: When several active slots match, the lowest slot number wins.
- R5: Slot 5 compares only the PID bits whose mask bit is 1. A mask bit of 0 makes that PID bit a don't-care. Slots 0 to 4 always compare all 13 bits.
- R6: While the default key is enabled, every lookup reports `res_hit`=1 and `res_dcw`=1, with `res_slot`, `res_cwpi` and `res_pes` all 0, whatever the slots contain.
- R7: A lookup that matches nothing reports `res_hit`=0, `res_dcw`=0, and `res_slot`, `res_cwpi`, `res_pes` all 0.
- R8: `in_ready` is 1 exactly when `res_valid` is 0 or `res_ready` is 1. A lookup is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and its result appears on the next cycle. While `res_valid` is 1 and `res_ready` is 0, every result field holds.
- R9: A write that occurs after a lookup is accepted does not change that lookup's result. Lookups accepted after the write see the new contents.
- R10: The write port decodes `wr_addr` as follows:
  - Addresses 0 to 5 load one slot: `wr_data[12:0]` is the PID, `wr_data[15:13]` is the index and `wr_data[16]` is the PES flag.
  - Address 6 loads the slot-5 mask from `wr_data[12:0]`.
  - Address 7 loads the default-key enable from `wr_data[0]`.
  - Addresses 8 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write target (see R10) |
| wr_data | input | 17 | Write payload |
| in_valid | input | 1 | Lookup request valid |
| in_ready | output | 1 | Lookup request accepted when high with in_valid |
| in_pid | input | 13 | PID of the packet being looked up |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Downstream takes the result |
| res_hit | output | 1 | Some slot or the default key applies |
| res_dcw | output | 1 | Default key selected |
| res_slot | output | 3 | Winning slot number |
| res_cwpi | output | 3 | Key pair index of the winning slot |
| res_pes | output | 1 | PES flag of the winning slot |

## Verification
The hardest situation to reach is a write that lands while a finished result is stalled on the output. The bench holds `res_ready` low after a lookup and keeps a second request waiting at the input. During the stall it rewrites the winning slot so that the slot is disabled. It then checks that the held result is unchanged, and that the waiting request, once released, sees the new contents. The priority logic is swept by making all six slots match the same PID and then disabling them one at a time. The wildcard slot is swept by clearing each of the 13 mask bits in turn.

// File: rtl/pidf_pkg.sv
package pidf_pkg;
  localparam int PID_W = 13;
  localparam int IDX_W = 3;
  localparam int WR_W  = PID_W + IDX_W + 1;

  // Index codes with both upper bits set mark a slot as inactive.
  function automatic logic idx_is_off(input logic [IDX_W-1:0] code);
    return &code[IDX_W-1:IDX_W-2];
  endfunction
endpackage

// File: rtl/pidf_regs.sv
module pidf_regs
  import pidf_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  output logic [PID_W-1:0]  pid_q  [NUM_SLOTS],
  output logic [IDX_W-1:0]  idx_q  [NUM_SLOTS],
  output logic              pes_q  [NUM_SLOTS],
  output logic [PID_W-1:0]  mask_q,
  output logic              dflt_q
);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_SLOTS);
  localparam logic [ADDR_W-1:0] DFLT_ADDR = ADDR_W'(NUM_SLOTS + 1);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pid_q[s] <= '0;
        idx_q[s] <= '1;
        pes_q[s] <= 1'b0;
      end else if (wr_en && wr_addr == ADDR_W'(s)) begin
        pid_q[s] <= wr_data[PID_W-1:0];
        idx_q[s] <= wr_data[PID_W+IDX_W-1:PID_W];
        pes_q[s] <= wr_data[WR_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      dflt_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == MASK_ADDR) mask_q <= wr_data[PID_W-1:0];
      if (wr_addr == DFLT_ADDR) dflt_q <= wr_data[0];
    end
  end
endmodule

// File: rtl/pidf_cmp.sv
module pidf_cmp
  import pidf_pkg::*;
#(
  parameter int NUM_SLOTS = 6
) (
  input  logic [PID_W-1:0]     pid,
  input  logic [PID_W-1:0]     pid_q [NUM_SLOTS],
  input  logic [IDX_W-1:0]     idx_q [NUM_SLOTS],
  input  logic [PID_W-1:0]     mask_q,
  output logic [NUM_SLOTS-1:0] hit_vec
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    logic [PID_W-1:0] care;
    if (s == NUM_SLOTS - 1) begin : g_wild
      assign care = mask_q;
    end else begin : g_exact
      assign care = '1;
    end
    assign hit_vec[s] = !idx_is_off(idx_q[s]) && (((pid ^ pid_q[s]) & care) == '0);
  end
endmodule

// File: rtl/pidf_prio.sv
module pidf_prio #(
  parameter int NUM_SLOTS = 6,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] vec,
  output logic                 any,
  output logic [SLOT_W-1:0]    win
);
  always_comb begin
    win = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (vec[i]) win = SLOT_W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/pidf_key_select.sv
module pidf_key_select
  import pidf_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int ADDR_W    = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PID_W-1:0]  in_pid,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic              res_dcw,
  output logic [SLOT_W-1:0] res_slot,
  output logic [IDX_W-1:0]  res_cwpi,
  output logic              res_pes
);
  logic [PID_W-1:0]     pid_q [NUM_SLOTS];
  logic [IDX_W-1:0]     idx_q [NUM_SLOTS];
  logic                 pes_q [NUM_SLOTS];
  logic [PID_W-1:0]     mask_q;
  logic                 dflt_q;
  logic [NUM_SLOTS-1:0] hit_vec;
  logic                 any_hit;
  logic [SLOT_W-1:0]    win;

  pidf_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pid_q(pid_q), .idx_q(idx_q), .pes_q(pes_q), .mask_q(mask_q), .dflt_q(dflt_q)
  );

  pidf_cmp #(.NUM_SLOTS(NUM_SLOTS)) u_cmp (
    .pid(in_pid), .pid_q(pid_q), .idx_q(idx_q), .mask_q(mask_q), .hit_vec(hit_vec)
  );

  pidf_prio #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_prio (
    .vec(hit_vec), .any(any_hit), .win(win)
  );

  logic              nx_hit, nx_dcw, nx_pes;
  logic [SLOT_W-1:0] nx_slot;
  logic [IDX_W-1:0]  nx_cwpi;

  always_comb begin
    nx_hit  = dflt_q | any_hit;
    nx_dcw  = dflt_q;
    nx_slot = '0;
    nx_cwpi = '0;
    nx_pes  = 1'b0;
    if (!dflt_q && any_hit) begin
      nx_slot = win;
      nx_cwpi = idx_q[win];
      nx_pes  = pes_q[win];
    end
  end

  assign in_ready = !res_valid || res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_dcw   <= 1'b0;
      res_slot  <= '0;
      res_cwpi  <= '0;
      res_pes   <= 1'b0;
    end else if (in_valid && in_ready) begin
      res_valid <= 1'b1;
      res_hit   <= nx_hit;
      res_dcw   <= nx_dcw;
      res_slot  <= nx_slot;
      res_cwpi  <= nx_cwpi;
      res_pes   <= nx_pes;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pidf_chk.sv
module pidf_chk #(
  parameter int SLOT_W = 3,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_hit,
  input logic              res_dcw,
  input logic [SLOT_W-1:0] res_slot,
  input logic [IDX_W-1:0]  res_cwpi,
  input logic              res_pes
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) && $stable(res_dcw)
      && $stable(res_slot) && $stable(res_cwpi) && $stable(res_pes)); // R8

  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> res_valid); // R8

  AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> !res_dcw && res_slot == '0 && res_cwpi == '0 && !res_pes); // R7

  AST_DEFAULT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_dcw |-> res_hit && res_slot == '0 && res_cwpi == '0 && !res_pes); // R6

  AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit && !res_dcw |-> res_cwpi[IDX_W-1:IDX_W-2] != 2'b11); // R3
endmodule

bind pidf_key_select pidf_chk #(.SLOT_W(SLOT_W), .IDX_W(pidf_pkg::IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit), .res_dcw(res_dcw),
  .res_slot(res_slot), .res_cwpi(res_cwpi), .res_pes(res_pes)
);

// File: tb/tb_pidf_key_select.sv
module tb_pidf_key_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [16:0] wr_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [12:0] in_pid = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit, res_dcw, res_pes;
  logic [2:0]  res_slot, res_cwpi;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [12:0] m_pid [6];
  logic [2:0]  m_idx [6];
  logic        m_pes [6];
  logic [12:0] m_mask;
  logic        m_dflt;

  always #10 clk = ~clk;

  pidf_key_select dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_pid(in_pid),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit), .res_dcw(res_dcw),
    .res_slot(res_slot), .res_cwpi(res_cwpi), .res_pes(res_pes)
  );

  // Expected {valid, hit, dcw, slot, cwpi, pes}
  function automatic logic [9:0] predict(input logic [12:0] p);
    logic [12:0] care;
    if (m_dflt) return {1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0};
    for (int i = 0; i < 6; i++) begin
      care = (i == 5) ? m_mask : 13'h1FFF;
      if (m_idx[i] < 3'd6 && ((p ^ m_pid[i]) & care) == 13'd0)
        return {1'b1, 1'b1, 1'b0, 3'(i), m_idx[i], m_pes[i]};
    end
    return {1'b1, 9'd0};
  endfunction

  function automatic logic [9:0] actual();
    return {res_valid, res_hit, res_dcw, res_slot, res_cwpi, res_pes};
  endfunction

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %03h expected %03h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [16:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 4'd6) begin
      m_pid[a] = d[12:0]; m_idx[a] = d[15:13]; m_pes[a] = d[16];
    end else if (a == 4'd6) m_mask = d[12:0];
    else if (a == 4'd7) m_dflt = d[0];
  endtask

  task automatic lookup(input string req, input logic [12:0] p);
    @(negedge clk);
    res_ready = 1'b1; in_valid = 1'b1; in_pid = p;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, actual(), predict(p));
  endtask

  function automatic logic [16:0] ent(input logic pes, input logic [2:0] idx, input logic [12:0] p);
    return {pes, idx, p};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] held;
    for (int i = 0; i < 6; i++) begin m_pid[i] = '0; m_idx[i] = 3'b111; m_pes[i] = 1'b0; end
    m_mask = 13'h1FFF; m_dflt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 ready/valid", {8'd0, in_ready, res_valid}, {8'd0, 1'b1, 1'b0});
    lookup("R1", 13'h0000);
    lookup("R1", 13'h0001);
    lookup("R1", 13'h1FFF);

    // R2/R3/R7: all eight index codes on slot 0
    for (int c = 0; c < 8; c++) begin
      wr(4'd0, ent(c[0], 3'(c), 13'h0100));
      lookup("R2 R3", 13'h0100);
      lookup("R7", 13'h0101);
    end

    // R4: all slots on one PID, disable from lowest upward
    for (int s = 0; s < 6; s++) wr(4'(s), ent(s[1], 3'(s), 13'h0055));
    for (int s = 0; s < 6; s++) begin
      lookup("R4", 13'h0055);
      wr(4'(s), ent(1'b0, 3'b110, 13'h0055));
    end
    lookup("R4 R3", 13'h0055);

    // R5: wildcard slot, each mask bit cleared in turn
    wr(4'd5, ent(1'b1, 3'd5, 13'h0A5A));
    for (int b = 0; b < 13; b++) begin
      wr(4'd6, {4'd0, ~(13'd1 << b)});
      lookup("R5 dontcare", 13'h0A5A ^ (13'd1 << b));
      lookup("R5 compared", 13'h0A5A ^ (13'd1 << ((b + 1) % 13)));
      lookup("R5 exact", 13'h0A5A);
    end
    wr(4'd6, 17'd0);
    lookup("R5 all", 13'h1FFF);
    lookup("R5 all", 13'h0000);
    wr(4'd6, {4'd0, 13'h1FFF});
    lookup("R5 restore", 13'h0A5B);
    lookup("R5 restore", 13'h0A5A);
    // R5: low slots ignore the mask
    wr(4'd2, ent(1'b0, 3'd3, 13'h0700));
    wr(4'd6, 17'd0);
    lookup("R5 slot2 exact", 13'h0701);
    lookup("R5 slot2 exact", 13'h0700);
    wr(4'd6, {4'd0, 13'h1FFF});

    // R6: default key override
    wr(4'd7, 17'd1);
    lookup("R6", 13'h0A5A);
    lookup("R6", 13'h0700);
    lookup("R6", 13'h0123);
    wr(4'd7, 17'd0);
    lookup("R6 off", 13'h0A5A);

    // R10: unused addresses change nothing
    for (int a = 8; a < 16; a++) wr(4'(a), 17'h1FFFF);
    lookup("R10", 13'h0A5A);
    lookup("R10", 13'h0700);
    lookup("R10", 13'h1FFF);

    // R8/R9: stall, rewrite winner, held result unchanged
    @(negedge clk);
    res_ready = 1'b0; in_valid = 1'b1; in_pid = 13'h0700;
    @(negedge clk);
    held = predict(13'h0700);
    check("R8 first", actual(), held);
    check("R8 in_ready low", {9'd0, in_ready}, 10'd0);
    in_pid = 13'h0700;  // second request kept waiting
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = ent(1'b0, 3'b111, 13'h0700);
    @(negedge clk);
    wr_en = 1'b0; m_idx[2] = 3'b111;
    repeat (2) @(negedge clk);
    check("R9 held", actual(), held);
    check("R8 held in_ready", {9'd0, in_ready}, 10'd0);
    res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 new", actual(), predict(13'h0700));
    @(negedge clk);
    check("R8 drained", {9'd0, res_valid}, 10'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule